// File: doc/BRIEF.md
# Routing Switchbox with Serial Configuration Chain

This block is the routing crossing at the corner of an island-style programmable array. Four sides (left, right, top, bottom) each carry their own number of tracks, given by parameters. Internally the crossing is a row of identical switch-point tiles, one per internal track. The number of tiles equals the widest side. Each tile holds six configuration bits, one for each pair of sides, and joins track t of one side only to track t of another side. On a narrower side, a per-side parameter map assigns a side wire to each internal track. This lets one external wire feed several internal tracks, and lets several tracks merge back onto that wire.

Routing is modelled one way. Every side has an input bus and an output bus. An output wire is the OR of all enabled sources that reach it. The configuration bits are loaded serially through a master/slave shift chain driven by two non-overlapping phase strobes, `cfg_phi1` and `cfg_phi2`, which are sampled on `clk`. A serial output lets several switchboxes be chained. Raising `cfg_done` freezes the chain, and only then are the routing outputs enabled.

The loader is a three-state machine. WAIT_P1 waits for a phase-1 strobe. WAIT_P2 holds a captured bit and waits for phase 2. FROZEN is the configured state. The named transitions are:
- P1_CAPTURE: WAIT_P1 to WAIT_P2, on phase 1 alone.
- P2_COMMIT: WAIT_P2 to WAIT_P1, on phase 2 alone.
- FREEZE: either wait state to FROZEN, on `cfg_done`.

FROZEN is left only through reset.

Top module: `sbox_top`

## Requirements
- R1: While `rst_n` is low, every configuration bit clears, the loader enters WAIT_P1, and all routing outputs and `cfg_sout` read 0.
- R2: In WAIT_P1, a cycle with `cfg_phi1`=1, `cfg_phi2`=0 and `cfg_done`=0 captures a shifted copy of the chain into the master stage. Master index NB-1 takes `cfg_sin`, and master index k takes slave index k+1. A following phase-2-only cycle in WAIT_P2 copies master to slave. So one bit enters per phase pair, and the first bit sent ends at chain index 0.
- R3: A phase-1 strobe in WAIT_P2 is ignored, a phase-2 strobe in WAIT_P1 is ignored, and a cycle with both strobes high changes nothing.
- R4: Chain index 6*t+p is switch p of tile t. The switch codes are: p=0 left-right, p=1 left-top, p=2 left-bottom, p=3 right-top, p=4 right-bottom, p=5 top-bottom. A switch joins only internal track t of its two sides, in both directions.
- R5: An output track is the OR of every enabled switch source reaching it. With all bits 0, every output is 0.
- R6: The tile count is the largest side width. Internal track t of a side is fed by the side wire named in 4-bit field t (bits 4t+3..4t) of that side's map. A field value not below the side width means wire t mod width, and this is the default. Side output wire j is the OR of the internal tracks mapped to j.
- R7: `cfg_done` moves the loader to FROZEN, which is kept until reset. Later phase strobes do not change the configuration.
- R8: `cfg_done` wins over a phase strobe in the same cycle. A freeze while in WAIT_P2 leaves the slave stage, and so the routing, as it was before that capture.
- R9: Before FROZEN, every routing output is 0 whatever the inputs and stored bits.
- R10: `cfg_sout` shows slave index 0, so each committed shift presents the next-oldest bit sent, for cascading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for strobes and chain |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_phi1 | input | 1 | Phase-1 strobe: capture into master |
| cfg_phi2 | input | 1 | Phase-2 strobe: commit master to slave |
| cfg_sin | input | 1 | Serial configuration input |
| cfg_done | input | 1 | Freeze chain and enable routing |
| cfg_sout | output | 1 | Serial configuration output |
| l_in | input | W_L | Left side incoming wires |
| l_out | output | W_L | Left side outgoing wires |
| r_in | input | W_R | Right side incoming wires |
| r_out | output | W_R | Right side outgoing wires |
| t_in | input | W_T | Top side incoming wires |
| t_out | output | W_T | Top side outgoing wires |
| b_in | input | W_B | Bottom side incoming wires |
| b_out | output | W_B | Bottom side outgoing wires |

## Verification
The freeze request and a phase strobe can fall in the same cycle. The bench provokes this in two ways. In the first, `cfg_done` rises in the very cycle that phase 1 carries a different bit. In the second, `cfg_done` rises between a phase-1 capture and its phase-2 commit, and the phase-2 strobe still arrives afterwards. In both cases the outcome is judged at the routing ports. The outputs must match a model of the configuration that was committed before the conflict, and `cfg_sout` must keep the oldest bit, which shows that neither the late capture nor the pending commit took effect.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    typedef enum logic [1:0] {
        S_WAIT_P1 = 2'd0,
        S_WAIT_P2 = 2'd1,
        S_FROZEN  = 2'd2
    } ld_state_t;

    localparam int PAIRS   = 6;
    localparam int P_LR    = 0;
    localparam int P_LT    = 1;
    localparam int P_LB    = 2;
    localparam int P_RT    = 3;
    localparam int P_RB    = 4;
    localparam int P_TB    = 5;
    localparam int FLD_W   = 4;
    localparam int MAX_TRK = 16;
    localparam int MAP_W   = FLD_W * MAX_TRK;

    // Side wire that feeds internal track t; out-of-range field falls back to t mod w.
    function automatic int src_of(input logic [MAP_W-1:0] map, input int t, input int w);
        int e;
        e = int'(map[t*FLD_W +: FLD_W]);
        if (e >= w) return t % w;
        return e;
    endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int NB = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phi1,
    input  logic          phi2,
    input  logic          sin,
    input  logic          done,
    output logic [NB-1:0] cfg,
    output logic          sout,
    output logic          frozen
);
    import sbox_pkg::*;

    ld_state_t     state, nxt;
    logic [NB-1:0] master, slave;
    logic          capture, commit;

    assign capture = (state == S_WAIT_P1) && !done && phi1 && !phi2;
    assign commit  = (state == S_WAIT_P2) && !done && phi2 && !phi1;

    always_comb begin
        nxt = state;
        unique case (state)
            S_WAIT_P1: begin
                if (done)                nxt = S_FROZEN;
                else if (phi1 && !phi2)  nxt = S_WAIT_P2;
            end
            S_WAIT_P2: begin
                if (done)                nxt = S_FROZEN;
                else if (phi2 && !phi1)  nxt = S_WAIT_P1;
            end
            S_FROZEN:                    nxt = S_FROZEN;
            default:                     nxt = S_WAIT_P1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_WAIT_P1;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master <= '0;
            slave  <= '0;
        end else begin
            if (capture) master <= {sin, slave[NB-1:1]};
            if (commit)  slave  <= master;
        end
    end

    assign cfg    = slave;
    assign sout   = slave[0];
    assign frozen = (state == S_FROZEN);

    // R7: freeze is sticky until reset
    a_r7_frozen_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FROZEN |=> state == S_FROZEN);

    // R7: stored configuration does not move once frozen
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FROZEN |=> $stable(slave));

    // R3: overlapping strobes leave both stages untouched
    a_r3_overlap_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (phi1 && phi2) |=> ($stable(master) && $stable(slave)));

    // R8: freeze request wins over any strobe in the same cycle
    a_r8_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(master) && $stable(slave)));

    // R2: a commit copies the captured master into the slave
    a_r2_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_P2 && phi2 && !phi1 && !done) |=> slave == $past(master));

endmodule

// File: rtl/sbox_tile.sv
module sbox_tile (
    input  logic                        a_l,
    input  logic                        a_r,
    input  logic                        a_t,
    input  logic                        a_b,
    input  logic [sbox_pkg::PAIRS-1:0]  sw,
    output logic                        y_l,
    output logic                        y_r,
    output logic                        y_t,
    output logic                        y_b
);
    import sbox_pkg::*;

    always_comb begin
        y_l = (sw[P_LR] & a_r) | (sw[P_LT] & a_t) | (sw[P_LB] & a_b);
        y_r = (sw[P_LR] & a_l) | (sw[P_RT] & a_t) | (sw[P_RB] & a_b);
        y_t = (sw[P_LT] & a_l) | (sw[P_RT] & a_r) | (sw[P_TB] & a_b);
        y_b = (sw[P_LB] & a_l) | (sw[P_RB] & a_r) | (sw[P_TB] & a_t);
    end

endmodule

// File: rtl/sbox_side_merge.sv
module sbox_side_merge #(
    parameter int                          W   = 3,
    parameter int                          NT  = 5,
    parameter logic [sbox_pkg::MAP_W-1:0]  MAP = '1
) (
    input  logic          en,
    input  logic [NT-1:0] trk,
    output logic [W-1:0]  wire_out
);
    for (genvar j = 0; j < W; j++) begin : g_wire
        logic acc;
        always_comb begin
            acc = 1'b0;
            for (int t = 0; t < NT; t++) begin
                if (sbox_pkg::src_of(MAP, t, W) == j) acc = acc | trk[t];
            end
        end
        assign wire_out[j] = en & acc;
    end

endmodule

// File: rtl/sbox_top.sv
module sbox_top #(
    parameter int                          W_L   = 3,
    parameter int                          W_R   = 5,
    parameter int                          W_T   = 2,
    parameter int                          W_B   = 4,
    parameter logic [sbox_pkg::MAP_W-1:0]  L_MAP = '1,
    parameter logic [sbox_pkg::MAP_W-1:0]  R_MAP = '1,
    parameter logic [sbox_pkg::MAP_W-1:0]  T_MAP = '1,
    parameter logic [sbox_pkg::MAP_W-1:0]  B_MAP = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_phi1,
    input  logic           cfg_phi2,
    input  logic           cfg_sin,
    input  logic           cfg_done,
    output logic           cfg_sout,
    input  logic [W_L-1:0] l_in,
    output logic [W_L-1:0] l_out,
    input  logic [W_R-1:0] r_in,
    output logic [W_R-1:0] r_out,
    input  logic [W_T-1:0] t_in,
    output logic [W_T-1:0] t_out,
    input  logic [W_B-1:0] b_in,
    output logic [W_B-1:0] b_out
);
    import sbox_pkg::*;

    localparam int MAX_LR = (W_L > W_R) ? W_L : W_R;
    localparam int MAX_TB = (W_T > W_B) ? W_T : W_B;
    localparam int NT     = (MAX_LR > MAX_TB) ? MAX_LR : MAX_TB;
    localparam int NB     = NT * PAIRS;

    logic [NB-1:0] cfg_bits;
    logic          frozen;
    logic [NT-1:0] al, ar, at, ab;
    logic [NT-1:0] yl, yr, yt, yb;

    sbox_cfg_chain #(.NB(NB)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .phi1   (cfg_phi1),
        .phi2   (cfg_phi2),
        .sin    (cfg_sin),
        .done   (cfg_done),
        .cfg    (cfg_bits),
        .sout   (cfg_sout),
        .frozen (frozen)
    );

    for (genvar t = 0; t < NT; t++) begin : g_trk
        localparam int SL = src_of(L_MAP, t, W_L);
        localparam int SR = src_of(R_MAP, t, W_R);
        localparam int ST = src_of(T_MAP, t, W_T);
        localparam int SB = src_of(B_MAP, t, W_B);

        assign al[t] = l_in[SL];
        assign ar[t] = r_in[SR];
        assign at[t] = t_in[ST];
        assign ab[t] = b_in[SB];

        sbox_tile u_tile (
            .a_l (al[t]),
            .a_r (ar[t]),
            .a_t (at[t]),
            .a_b (ab[t]),
            .sw  (cfg_bits[t*PAIRS +: PAIRS]),
            .y_l (yl[t]),
            .y_r (yr[t]),
            .y_t (yt[t]),
            .y_b (yb[t])
        );
    end

    sbox_side_merge #(.W(W_L), .NT(NT), .MAP(L_MAP)) u_mrg_l (.en(frozen), .trk(yl), .wire_out(l_out));
    sbox_side_merge #(.W(W_R), .NT(NT), .MAP(R_MAP)) u_mrg_r (.en(frozen), .trk(yr), .wire_out(r_out));
    sbox_side_merge #(.W(W_T), .NT(NT), .MAP(T_MAP)) u_mrg_t (.en(frozen), .trk(yt), .wire_out(t_out));
    sbox_side_merge #(.W(W_B), .NT(NT), .MAP(B_MAP)) u_mrg_b (.en(frozen), .trk(yb), .wire_out(b_out));

    // R9: nothing leaves the switchbox before the loader is frozen
    a_r9_gated_until_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !frozen |-> (l_out == '0 && r_out == '0 && t_out == '0 && b_out == '0));

    // R5: an empty configuration drives nothing
    a_r5_cleared_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bits == '0) |-> (l_out == '0 && r_out == '0 && t_out == '0 && b_out == '0));

endmodule

// File: tb/sbox_top_tb.sv
module sbox_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WL = 3;
    localparam int WR = 5;
    localparam int WT = 2;
    localparam int WB = 4;
    localparam int NT = 5;
    localparam int NB = NT * 6;
    localparam int NV = 8;
    // stimulus packing: {l(3), t(2), b(4), r(5)}
    localparam logic [13:0] VEC [NV] = '{14'h0000, 14'h3FFF, 14'h0800, 14'h0200,
                                         14'h0020, 14'h0001, 14'h1555, 14'h2AAA};

    logic clk = 1'b0;
    logic rst_n, phi1, phi2, sin, done;
    logic sout;
    logic [WL-1:0] l_in, l_out;
    logic [WR-1:0] r_in, r_out;
    logic [WT-1:0] t_in, t_out;
    logic [WB-1:0] b_in, b_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit cfgv [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    sbox_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_phi1(phi1), .cfg_phi2(phi2), .cfg_sin(sin),
        .cfg_done(done), .cfg_sout(sout),
        .l_in(l_in), .l_out(l_out), .r_in(r_in), .r_out(r_out),
        .t_in(t_in), .t_out(t_out), .b_in(b_in), .b_out(b_out)
    );

    function automatic logic [13:0] model(input logic [13:0] v);
        logic [WL-1:0] il, ol;
        logic [WT-1:0] it, ot;
        logic [WB-1:0] ib, ob;
        logic [WR-1:0] ir, orr;
        {il, it, ib, ir} = v;
        ol = '0; ot = '0; ob = '0; orr = '0;
        for (int t = 0; t < NT; t++) begin
            logic a_l, a_r, a_t, a_b;
            logic [5:0] c;
            a_l = il[t % WL]; a_r = ir[t % WR]; a_t = it[t % WT]; a_b = ib[t % WB];
            for (int p = 0; p < 6; p++) c[p] = cfgv[t*6 + p];
            ol[t % WL]  |= (c[0] & a_r) | (c[1] & a_t) | (c[2] & a_b);
            orr[t % WR] |= (c[0] & a_l) | (c[3] & a_t) | (c[4] & a_b);
            ot[t % WT]  |= (c[1] & a_l) | (c[3] & a_r) | (c[5] & a_b);
            ob[t % WB]  |= (c[2] & a_l) | (c[4] & a_r) | (c[5] & a_t);
        end
        return {ol, ot, ob, orr};
    endfunction

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; phi1 = 1'b0; phi2 = 1'b0; sin = 1'b0; done = 1'b0;
        {l_in, t_in, b_in, r_in} = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); phi1 = 1'b1; sin = b;
        @(negedge clk); phi1 = 1'b0; phi2 = 1'b1;
        @(negedge clk); phi2 = 1'b0;
    endtask

    task automatic load_cfg(input int upto);
        for (int i = 0; i < upto; i++) shift_bit(cfgv[i]);
    endtask

    task automatic freeze();
        @(negedge clk); done = 1'b1;
    endtask

    task automatic probe(input string req, input logic [13:0] v, input logic [13:0] exp);
        @(negedge clk);
        {l_in, t_in, b_in, r_in} = v;
        #1;
        chk(req, {l_out, t_out, b_out, r_out}, exp);
    endtask

    task automatic cfg_clear();
        for (int i = 0; i < NB; i++) cfgv[i] = 1'b0;
    endtask

    task automatic cfg_pattern_a();
        for (int i = 0; i < NB; i++) cfgv[i] = (((i * 5 + 2) % 7) < 3);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        @(negedge clk); rst_n = 1'b0; {l_in, t_in, b_in, r_in} = 14'h3FFF;
        @(negedge clk); #1;
        chk("R1 outputs in reset", {l_out, t_out, b_out, r_out}, 14'h0000);
        chk("R1 sout in reset", {13'd0, sout}, 14'h0000);
        rst_n = 1'b1;

        // R5: all-clear configuration drives nothing
        do_reset(); cfg_clear(); load_cfg(NB); freeze();
        probe("R5 cleared config", 14'h3FFF, 14'h0000);

        // R9 then R2/R5/R6 table walk with pattern A
        do_reset(); cfg_pattern_a(); load_cfg(NB);
        probe("R9 gated before freeze", 14'h3FFF, 14'h0000);
        chk("R10 sout shows first bit", {13'd0, sout}, {13'd0, cfgv[0]});
        freeze();
        for (int k = 0; k < NV; k++) probe("R2 R5 R6 table", VEC[k], model(VEC[k]));

        // R7: strobes after freeze change nothing
        for (int k = 0; k < 4; k++) shift_bit(1'b1);
        probe("R7 frozen routing", 14'h3FFF, model(14'h3FFF));
        probe("R7 frozen routing alt", 14'h1555, model(14'h1555));
        chk("R7 frozen sout", {13'd0, sout}, {13'd0, cfgv[0]});

        // R10: extra shifts push out older bits in order
        do_reset(); cfg_pattern_a(); load_cfg(NB);
        shift_bit(1'b0);
        chk("R10 sout second bit", {13'd0, sout}, {13'd0, cfgv[1]});
        shift_bit(1'b0);
        chk("R10 sout third bit", {13'd0, sout}, {13'd0, cfgv[2]});

        // R4: each pair code on track 1, all inputs high
        for (int p = 0; p < 6; p++) begin
            do_reset(); cfg_clear(); cfgv[6 + p] = 1'b1; load_cfg(NB); freeze();
            probe("R4 pair position", 14'h3FFF, model(14'h3FFF));
            probe("R4 pair single source", 14'h0821, model(14'h0821));
        end
        do_reset(); cfg_clear(); cfgv[6] = 1'b1; load_cfg(NB); freeze();
        probe("R4 left-right on track 1", 14'h3FFF, 14'h1002);

        // R6: left wire 0 duplicated onto track 3 (3 mod 3)
        do_reset(); cfg_clear(); cfgv[18] = 1'b1; load_cfg(NB); freeze();
        probe("R6 left wire 0 reaches right track 3", 14'h0800, 14'h0008);
        probe("R6 right track 3 merges to left wire 0", 14'h0008, 14'h0800);

        // R3: a second phase 1 and an overlapped pair are ignored
        do_reset(); cfg_pattern_a(); load_cfg(NB - 1);
        @(negedge clk); phi1 = 1'b1; phi2 = 1'b1; sin = 1'b1;
        @(negedge clk); phi1 = 1'b0; phi2 = 1'b0;
        @(negedge clk); phi1 = 1'b1; sin = cfgv[NB-1];
        @(negedge clk); sin = ~cfgv[NB-1];
        @(negedge clk); phi1 = 1'b0; phi2 = 1'b1;
        @(negedge clk); phi2 = 1'b0;
        freeze();
        probe("R3 ordering all-high", 14'h3FFF, model(14'h3FFF));
        probe("R3 ordering mixed", 14'h2AAA, model(14'h2AAA));
        chk("R3 sout first bit", {13'd0, sout}, {13'd0, cfgv[0]});

        // R8: freeze in the same cycle as phase 1
        do_reset(); cfg_pattern_a(); load_cfg(NB);
        @(negedge clk); phi1 = 1'b1; sin = ~cfgv[0]; done = 1'b1;
        @(negedge clk); phi1 = 1'b0; phi2 = 1'b1;
        @(negedge clk); phi2 = 1'b0;
        probe("R8 done with phase 1", 14'h3FFF, model(14'h3FFF));
        chk("R8 sout kept", {13'd0, sout}, {13'd0, cfgv[0]});

        // R8: freeze while waiting for phase 2
        do_reset(); cfg_pattern_a(); load_cfg(NB);
        @(negedge clk); phi1 = 1'b1; sin = ~cfgv[0];
        @(negedge clk); phi1 = 1'b0; done = 1'b1;
        @(negedge clk); phi2 = 1'b1;
        @(negedge clk); phi2 = 1'b0;
        probe("R8 pending commit dropped", 14'h3FFF, model(14'h3FFF));
        probe("R8 pending commit dropped alt", 14'h1555, model(14'h1555));
        chk("R8 sout after pending", {13'd0, sout}, {13'd0, cfgv[0]});

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule